// File: doc/BRIEF.md
# Asynchronous Serial Port with Read-Armed Status Clearing

This block is an asynchronous serial transmitter and receiver placed behind a small byte-wide register interface. Software programs a bit-rate divider and a clock prescaler, enables the transmitter and receiver, writes bytes to send and reads bytes received. Frames carry one start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit. Every bit lasts 32 sub-bit ticks, and the tick rate is set by the divider and the prescaler.

Six status flags report the state of the transfer: transmit-data-empty, receive-data-full, overrun, framing error, parity error and transmit-end. Software clears a flag by writing 0 to its bit. That write only acts on a flag that was already 1 when software last read the status register, so an event that arrives between the read and the write is never lost. Three interrupt outputs combine the flags with enable bits in the control register.

The transmitter state machine has the states TX_IDLE, TX_START, TX_DATA, TX_PAR and TX_STOP.
- TX_IDLE goes to TX_START when the transmitter is enabled and a byte is pending. This is a load.
- TX_START goes to TX_DATA after one bit time.
- TX_DATA goes to TX_PAR after the eighth bit when parity is on. It goes to TX_STOP when parity is off.
- TX_PAR goes to TX_STOP.
- TX_STOP goes to TX_START when another byte is pending, which is a back-to-back load. Otherwise it goes to TX_IDLE and sets transmit-end.

The receiver state machine has the states RX_IDLE, RX_START, RX_DATA, RX_PAR and RX_STOP.
- RX_IDLE goes to RX_START on a tick that sees the line low.
- RX_START goes to RX_DATA when the line is still low at the middle of the start bit. It goes back to RX_IDLE on a false start.
- RX_DATA goes to RX_PAR or to RX_STOP after eight samples.
- RX_PAR goes to RX_STOP.
- RX_STOP goes to RX_IDLE once it has sampled the stop bit.
- Clearing the receive enable forces the receiver to RX_IDLE from any state.

Top module: `sci_top`

## Requirements
- R1: After reset the status register at offset 0x8 reads 0x84 (transmit-empty bit 7 and transmit-end bit 2 set). The control register at offset 0x4 reads 0x30, the mode register at offset 0x0 reads 0x00, txd is 1 and all interrupt outputs are 0. The other offsets are: bit-rate 0x2, transmit data 0x6 and receive data 0xA.
- R2: One bit lasts 32·(N+1)·P clocks. N is the bit-rate register value. P is 1, 4, 16 or 64 for mode bits [1:0] = 0, 1, 2 or 3.
- R3: With the transmitter enabled (control bit 5) and transmit-empty at 0, the block loads the transmit data register and sets transmit-empty. It then sends a 0 start bit, eight data bits LSB first, a parity bit when mode bit 5 is 1, and a 1 stop bit. The parity is even, or odd when mode bit 4 is 1.
- R4: When a stop bit ends with no byte pending, transmit-end sets and txd stays 1. With the transmitter disabled, no frame starts and transmit-empty stays 0.
- R5: With the receiver enabled (control bit 4), each bit is sampled at its middle. A completed frame writes the receive data register and sets receive-full (bit 6). With the receiver disabled, line activity changes neither.
- R6: A frame that completes while receive-full is 1 sets overrun (bit 5). Its byte is discarded and the receive data register keeps its value.
- R7: A stop bit sampled as 0 sets framing error (bit 4). A parity bit that mismatches sets parity error (bit 3).
- R8: Writing 0 to a status bit that was 1 at the last status read clears it. Writing 1 leaves the bit unchanged. 0xBC clears receive-full, 0xC4 clears the three errors and 0x78 clears transmit-empty and transmit-end.
- R9: A flag that sets after the last status read survives a clearing write. A write disarms the bits it cleared until the next read.
- R10: irq_tx is transmit-empty AND control bit 7. irq_rx is receive-full AND control bit 6. irq_err is the OR of the three error flags AND control bit 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms status clears) |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq_tx | output | 1 | Transmit interrupt request |
| irq_rx | output | 1 | Receive interrupt request |
| irq_err | output | 1 | Receive error interrupt request |

## Verification
The hardest case is a flag that rises in the gap between a status read and the clearing write. From the ports this takes a status read taken while receive-full is 0, then a whole serial frame delivered on rxd, and only then the write of 0xBC. The bench builds exactly that ordering and then shows that a fresh read followed by the same write does clear the flag. Overrun is reached the same way: a second frame is sent while the first byte is held unread.

// File: rtl/sci_pkg.sv
package sci_pkg;
    localparam int REG_AW = 4;

    localparam logic [REG_AW-1:0] A_MODE  = 4'h0;
    localparam logic [REG_AW-1:0] A_RATE  = 4'h2;
    localparam logic [REG_AW-1:0] A_CTRL  = 4'h4;
    localparam logic [REG_AW-1:0] A_TDATA = 4'h6;
    localparam logic [REG_AW-1:0] A_STAT  = 4'h8;
    localparam logic [REG_AW-1:0] A_RDATA = 4'hA;

    localparam int S_TXE  = 7;
    localparam int S_RXF  = 6;
    localparam int S_OVR  = 5;
    localparam int S_FRM  = 4;
    localparam int S_PAR  = 3;
    localparam int S_TXD  = 2;

    localparam int C_TIE = 7;
    localparam int C_RIE = 6;
    localparam int C_TEN = 5;
    localparam int C_REN = 4;

    localparam int M_PEN = 5;
    localparam int M_ODD = 4;

    localparam logic [7:0] STAT_RESET = 8'h84;
    localparam logic [7:0] CTRL_RESET = 8'h30;
    localparam logic [7:0] RATE_RESET = 8'hFF;
    localparam logic [7:0] FLAG_MASK  = 8'hFC;

    typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP} tx_state_e;
    typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP} rx_state_e;
endpackage

// File: rtl/sci_baud.sv
module sci_baud #(
    parameter int RATE_W    = 8,
    parameter int PSC_STEPS = 4,
    parameter int PSC_SHIFT = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [$clog2(PSC_STEPS)-1:0] psc_sel,
    input  logic [RATE_W-1:0]            rate,
    output logic                         tick
);
    localparam int PSC_W = PSC_SHIFT * (PSC_STEPS - 1);

    logic [PSC_W-1:0]  psc_cnt;
    logic [PSC_W-1:0]  psc_lim;
    logic [PSC_W:0]    psc_pow;
    logic [RATE_W-1:0] div_cnt;

    always_comb begin
        psc_pow = (PSC_W+1)'(1) << (PSC_SHIFT * int'(psc_sel));
        psc_lim = PSC_W'(psc_pow - 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_cnt <= '0;
            div_cnt <= '0;
            tick    <= 1'b0;
        end else begin
            tick <= 1'b0;
            if (psc_cnt >= psc_lim) begin
                psc_cnt <= '0;
                if (div_cnt >= rate) begin
                    div_cnt <= '0;
                    tick    <= 1'b1;
                end else begin
                    div_cnt <= div_cnt + 1'b1;
                end
            end else begin
                psc_cnt <= psc_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sci_tx.sv
module sci_tx
    import sci_pkg::*;
#(
    parameter int DW    = 8,
    parameter int TICKS = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          enable,
    input  logic          pending,
    input  logic [DW-1:0] tdata,
    input  logic          par_en,
    input  logic          par_odd,
    output logic          load,
    output logic          fin,
    output logic          busy,
    output logic          txd
);
    localparam int SUB_W = $clog2(TICKS);
    localparam int BIT_W = $clog2(DW);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(TICKS - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DW - 1);

    tx_state_e        st, nxt;
    logic [SUB_W-1:0] sub;
    logic [BIT_W-1:0] bitn;
    logic [DW-1:0]    shreg;
    logic             pbit;
    logic             bit_end;

    assign bit_end = tick && (sub == SUB_LAST);

    always_comb begin
        nxt  = st;
        load = 1'b0;
        fin  = 1'b0;
        unique case (st)
            TX_IDLE:  if (enable && pending) begin
                          load = 1'b1;
                          nxt  = TX_START;
                      end
            TX_START: if (bit_end) nxt = TX_DATA;
            TX_DATA:  if (bit_end && bitn == BIT_LAST) nxt = par_en ? TX_PAR : TX_STOP;
            TX_PAR:   if (bit_end) nxt = TX_STOP;
            TX_STOP:  if (bit_end) begin
                          if (enable && pending) begin
                              load = 1'b1;
                              nxt  = TX_START;
                          end else begin
                              fin = 1'b1;
                              nxt = TX_IDLE;
                          end
                      end
            default:  nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= TX_IDLE;
            sub   <= '0;
            bitn  <= '0;
            shreg <= '0;
            pbit  <= 1'b0;
        end else begin
            st <= nxt;
            if (load) begin
                shreg <= tdata;
                pbit  <= (^tdata) ^ par_odd;
                sub   <= '0;
                bitn  <= '0;
            end else if (tick && st != TX_IDLE) begin
                sub <= (sub == SUB_LAST) ? '0 : sub + 1'b1;
                if (bit_end && st == TX_DATA) begin
                    shreg <= shreg >> 1;
                    bitn  <= bitn + 1'b1;
                end
            end
        end
    end

    always_comb begin
        busy = (st != TX_IDLE);
        unique case (st)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = shreg[0];
            TX_PAR:   txd = pbit;
            default:  txd = 1'b1;
        endcase
    end
endmodule

// File: rtl/sci_rx.sv
module sci_rx
    import sci_pkg::*;
#(
    parameter int DW    = 8,
    parameter int TICKS = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          enable,
    input  logic          line,
    input  logic          par_en,
    input  logic          par_odd,
    output logic          done,
    output logic [DW-1:0] data,
    output logic          frm_err,
    output logic          par_err
);
    localparam int SUB_W = $clog2(TICKS);
    localparam int BIT_W = $clog2(DW);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(TICKS - 1);
    localparam logic [SUB_W-1:0] SUB_HALF = SUB_W'(TICKS / 2 - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DW - 1);

    rx_state_e        st, nxt;
    logic [SUB_W-1:0] sub;
    logic [BIT_W-1:0] bitn;
    logic [DW-1:0]    shreg;
    logic             pbit;
    logic             sample;
    logic             mid_start;

    assign sample    = tick && (sub == SUB_LAST);
    assign mid_start = tick && (sub == SUB_HALF);

    always_comb begin
        nxt = st;
        if (!enable) begin
            nxt = RX_IDLE;
        end else begin
            unique case (st)
                RX_IDLE:  if (tick && !line) nxt = RX_START;
                RX_START: if (mid_start) nxt = line ? RX_IDLE : RX_DATA;
                RX_DATA:  if (sample && bitn == BIT_LAST) nxt = par_en ? RX_PAR : RX_STOP;
                RX_PAR:   if (sample) nxt = RX_STOP;
                RX_STOP:  if (sample) nxt = RX_IDLE;
                default:  nxt = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= RX_IDLE;
            sub   <= '0;
            bitn  <= '0;
            shreg <= '0;
            pbit  <= 1'b0;
        end else begin
            st <= nxt;
            if (st == RX_IDLE) begin
                sub  <= '0;
                bitn <= '0;
            end else if (st == RX_START) begin
                if (tick) sub <= mid_start ? '0 : sub + 1'b1;
            end else if (tick) begin
                sub <= (sub == SUB_LAST) ? '0 : sub + 1'b1;
                if (sample && st == RX_DATA) begin
                    shreg <= {line, shreg[DW-1:1]};
                    bitn  <= bitn + 1'b1;
                end
                if (sample && st == RX_PAR) pbit <= line;
            end
        end
    end

    always_comb begin
        done    = enable && (st == RX_STOP) && sample;
        data    = shreg;
        frm_err = !line;
        par_err = par_en && (pbit != ((^shreg) ^ par_odd));
    end
endmodule

// File: rtl/sci_top.sv
module sci_top
    import sci_pkg::*;
#(
    parameter int DW        = 8,
    parameter int TICKS     = 32,
    parameter int PSC_STEPS = 4,
    parameter int PSC_SHIFT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              rxd,
    output logic              txd,
    output logic              irq_tx,
    output logic              irq_rx,
    output logic              irq_err
);
    localparam int PSEL_W = $clog2(PSC_STEPS);

    logic [7:0]    mode_q, rate_q, ctrl_q;
    logic [DW-1:0] tdr_q, rdr_q;
    logic [7:0]    flags, seen;
    logic [7:0]    hw_set, sw_clr;
    logic [1:0]    rx_sync;
    logic          tick;
    logic          tx_load, tx_fin, tx_busy;
    logic          rx_done, rx_frm, rx_par;
    logic [DW-1:0] rx_data;
    logic          stat_wr, stat_rd;

    assign stat_wr = bus_wr && bus_addr == A_STAT;
    assign stat_rd = bus_rd && bus_addr == A_STAT;

    sci_baud #(.RATE_W(8), .PSC_STEPS(PSC_STEPS), .PSC_SHIFT(PSC_SHIFT)) u_baud (
        .clk(clk), .rst_n(rst_n), .psc_sel(mode_q[PSEL_W-1:0]), .rate(rate_q), .tick(tick)
    );

    sci_tx #(.DW(DW), .TICKS(TICKS)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .enable(ctrl_q[C_TEN]),
        .pending(!flags[S_TXE]), .tdata(tdr_q), .par_en(mode_q[M_PEN]),
        .par_odd(mode_q[M_ODD]), .load(tx_load), .fin(tx_fin), .busy(tx_busy), .txd(txd)
    );

    sci_rx #(.DW(DW), .TICKS(TICKS)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .enable(ctrl_q[C_REN]), .line(rx_sync[1]),
        .par_en(mode_q[M_PEN]), .par_odd(mode_q[M_ODD]), .done(rx_done), .data(rx_data),
        .frm_err(rx_frm), .par_err(rx_par)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_sync <= 2'b11;
        else        rx_sync <= {rx_sync[0], rxd};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            rate_q <= RATE_RESET;
            ctrl_q <= CTRL_RESET;
            tdr_q  <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_MODE)  mode_q <= bus_wdata;
            if (bus_addr == A_RATE)  rate_q <= bus_wdata;
            if (bus_addr == A_CTRL)  ctrl_q <= bus_wdata;
            if (bus_addr == A_TDATA) tdr_q  <= bus_wdata[DW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           rdr_q <= '0;
        else if (rx_done && !flags[S_RXF])    rdr_q <= rx_data;
    end

    always_comb begin
        hw_set        = '0;
        hw_set[S_TXE] = tx_load;
        hw_set[S_TXD] = tx_fin;
        hw_set[S_RXF] = rx_done && !flags[S_RXF];
        hw_set[S_OVR] = rx_done &&  flags[S_RXF];
        hw_set[S_FRM] = rx_done && !flags[S_RXF] && rx_frm;
        hw_set[S_PAR] = rx_done && !flags[S_RXF] && rx_par;
        sw_clr        = stat_wr ? (~bus_wdata & seen) : '0;
    end

    for (genvar b = 0; b < 8; b++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags[b] <= STAT_RESET[b];
                seen[b]  <= 1'b0;
            end else begin
                flags[b] <= FLAG_MASK[b] & (hw_set[b] | (flags[b] & ~sw_clr[b]));
                if (stat_rd)      seen[b] <= flags[b];
                else if (stat_wr) seen[b] <= seen[b] & bus_wdata[b];
            end
        end
    end

    always_comb begin
        unique case (bus_addr)
            A_MODE:  bus_rdata = mode_q;
            A_RATE:  bus_rdata = rate_q;
            A_CTRL:  bus_rdata = ctrl_q;
            A_TDATA: bus_rdata = 8'(tdr_q);
            A_STAT:  bus_rdata = flags;
            A_RDATA: bus_rdata = 8'(rdr_q);
            default: bus_rdata = '0;
        endcase
    end

    assign irq_tx  = flags[S_TXE] & ctrl_q[C_TIE];
    assign irq_rx  = flags[S_RXF] & ctrl_q[C_RIE];
    assign irq_err = (flags[S_OVR] | flags[S_FRM] | flags[S_PAR]) & ctrl_q[C_RIE];
endmodule

// File: rtl/sci_checker.sv
module sci_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic [3:0] bus_addr,
    input logic       wd_ovr,
    input logic       txe,
    input logic       rxf,
    input logic       ovr,
    input logic       seen_rxf,
    input logic       tx_load,
    input logic       tx_busy,
    input logic       txd,
    input logic       rx_done,
    input logic [7:0] rdr
);
    logic stat_wr;
    assign stat_wr = bus_wr && bus_addr == 4'h8;

    // R3: a load always leaves transmit-empty set
    assert_load_sets_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> txe);

    // R4: line idles high whenever no frame is in flight
    assert_idle_line_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);

    // R6: an overrun frame keeps the held byte and raises overrun
    assert_overrun_keeps_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rxf) |=> ($stable(rdr) && ovr));

    // R8: writing 1 to a set overrun bit keeps it
    assert_write_one_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && wd_ovr && ovr) |=> ovr);

    // R9: receive-full not seen at the last read survives a clear write
    assert_unseen_flag_survives_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !seen_rxf && rxf) |=> rxf);
endmodule

bind sci_top sci_checker u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .wd_ovr(bus_wdata[5]), .txe(flags[7]), .rxf(flags[6]), .ovr(flags[5]),
    .seen_rxf(seen[6]), .tx_load(tx_load), .tx_busy(tx_busy), .txd(txd),
    .rx_done(rx_done), .rdr(rdr_q)
);

// File: tb/tb_sci_top.sv
module tb_sci_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0] bus_addr = 4'h8;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       rxd = 1'b1;
    logic       txd, irq_tx, irq_rx, irq_err;

    int         n_run = 0, n_fail = 0;
    logic [7:0] ctrl_m = 8'h30;
    int         bitclk = 128;

    always #10 clk = ~clk;

    sci_top dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rxd(rxd), .txd(txd),
        .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        if (a == 4'h4) ctrl_m = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 4'h8;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #5 d = bus_rdata;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0; bus_addr = 4'h8;
    endtask

    task automatic send(input logic [7:0] d, input bit pen, input bit odd,
                        input bit bad_par, input bit bad_stop);
        @(negedge clk);
        rxd = 1'b0;
        repeat (bitclk) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i];
            repeat (bitclk) @(negedge clk);
        end
        if (pen) begin
            rxd = (^d) ^ odd ^ bad_par;
            repeat (bitclk) @(negedge clk);
        end
        rxd = !bad_stop;
        repeat (bitclk) @(negedge clk);
        rxd = 1'b1;
        repeat (bitclk) @(negedge clk);
    endtask

    task automatic recv(input bit pen, output logic [7:0] d, output logic p, output logic stop);
        int w;
        w = 0; d = 'x; p = 'x; stop = 'x;
        while (txd !== 1'b0 && w < 20 * bitclk) begin
            @(negedge clk);
            w++;
        end
        if (txd !== 1'b0) return;
        repeat (bitclk / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            repeat (bitclk) @(negedge clk);
            d[i] = txd;
        end
        if (pen) begin
            repeat (bitclk) @(negedge clk);
            p = txd;
        end
        repeat (bitclk) @(negedge clk);
        stop = txd;
    endtask

    task automatic start_width(output int w);
        int g;
        g = 0; w = 0;
        while (txd !== 1'b0 && g < 40000) begin
            @(negedge clk);
            g++;
        end
        while (txd === 1'b0 && w < 40000) begin
            @(negedge clk);
            w++;
        end
    endtask

    task automatic kick_tx(input logic [7:0] d);
        logic [7:0] s;
        wr(4'h6, d);
        rd(4'h8, s);
        wr(4'h8, 8'h78);
    endtask

    // R10: interrupt outputs compared on every clock against the status read path
    always @(posedge clk) begin
        #5;
        if (rst_n && bus_addr == 4'h8) begin
            chk(irq_tx  == (bus_rdata[7] & ctrl_m[7]), "R10 irq_tx", irq_tx, bus_rdata[7] & ctrl_m[7]);
            chk(irq_rx  == (bus_rdata[6] & ctrl_m[6]), "R10 irq_rx", irq_rx, bus_rdata[6] & ctrl_m[6]);
            chk(irq_err == ((|bus_rdata[5:3]) & ctrl_m[6]), "R10 irq_err", irq_err,
                (|bus_rdata[5:3]) & ctrl_m[6]);
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v, d;
        logic       p, s;
        int         w;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(4'h8, v); chk_eq("R1 status reset", v, 8'h84);
        rd(4'h4, v); chk_eq("R1 ctrl reset", v, 8'h30);
        rd(4'h0, v); chk_eq("R1 mode reset", v, 8'h00);
        chk_eq("R1 txd idle", txd, 1);
        chk_eq("R1 irqs", {irq_tx, irq_rx, irq_err}, 0);

        // R3: plain frame
        wr(4'h2, 8'd3); bitclk = 128;
        kick_tx(8'h5A);
        recv(1'b0, d, p, s);
        chk_eq("R3 tx data 5A", d, 8'h5A);
        chk_eq("R3 tx stop", s, 1);
        repeat (2 * bitclk) @(negedge clk);
        rd(4'h8, v); chk_eq("R4 tend after frame", v, 8'h84);
        chk_eq("R4 txd idle", txd, 1);

        // R3: parity even then odd
        wr(4'h0, 8'h20);
        kick_tx(8'hA5);
        recv(1'b1, d, p, s);
        chk_eq("R3 even data", d, 8'hA5);
        chk_eq("R3 even parity", p, 0);
        repeat (2 * bitclk) @(negedge clk);
        wr(4'h0, 8'h30);
        kick_tx(8'hA5);
        recv(1'b1, d, p, s);
        chk_eq("R3 odd parity", p, 1);
        repeat (2 * bitclk) @(negedge clk);

        // R2: prescaler 4 with N=1 -> 256 clocks; prescaler 16 with N=0 -> 512 clocks
        wr(4'h0, 8'h01); wr(4'h2, 8'd1);
        kick_tx(8'h01);
        start_width(w);
        chk(w >= 248 && w <= 257, "R2 bit width psc4", w, 256);
        repeat (12 * 256) @(negedge clk);
        wr(4'h0, 8'h02); wr(4'h2, 8'd0);
        kick_tx(8'h01);
        start_width(w);
        chk(w >= 496 && w <= 513, "R2 bit width psc16", w, 512);
        repeat (12 * 512) @(negedge clk);
        wr(4'h0, 8'h00); wr(4'h2, 8'd3); bitclk = 128;

        // R4: transmitter disabled holds the byte
        wr(4'h4, 8'h10);
        kick_tx(8'h66);
        w = 0;
        repeat (3 * bitclk) begin
            @(negedge clk);
            if (txd !== 1'b1) w++;
        end
        chk_eq("R4 no frame when disabled", w, 0);
        rd(4'h8, v); chk_eq("R4 empty stays clear", v, 8'h00);
        wr(4'h4, 8'h30);
        recv(1'b0, d, p, s);
        chk_eq("R4 frame after enable", d, 8'h66);
        repeat (2 * bitclk) @(negedge clk);
        rd(4'h8, v); chk_eq("R4 status after enable", v, 8'h84);

        // R5: receive
        send(8'h3C, 0, 0, 0, 0);
        rd(4'h8, v); chk_eq("R5 rx full", v, 8'hC4);
        rd(4'hA, v); chk_eq("R5 rx data", v, 8'h3C);

        // R6: overrun
        send(8'hC3, 0, 0, 0, 0);
        rd(4'h8, v); chk_eq("R6 overrun flag", v, 8'hE4);
        rd(4'hA, v); chk_eq("R6 byte kept", v, 8'h3C);

        // R8: write 1 keeps, write 0 clears seen flags
        wr(4'h8, 8'hFF);
        rd(4'h8, v); chk_eq("R8 write one keeps", v, 8'hE4);
        wr(4'h8, 8'hC4);
        rd(4'h8, v); chk_eq("R8 error clear", v, 8'hC4);
        rd(4'hA, v);
        wr(4'h8, 8'hBC);
        rd(4'h8, v); chk_eq("R8 rx full clear", v, 8'h84);

        // R9: flag raised after the read survives
        send(8'h11, 0, 0, 0, 0);
        wr(4'h8, 8'hBC);
        rd(4'h8, v); chk_eq("R9 unseen survives", v, 8'hC4);
        rd(4'hA, v); chk_eq("R9 data", v, 8'h11);
        wr(4'h8, 8'hBC);
        rd(4'h8, v); chk_eq("R9 seen then cleared", v, 8'h84);

        // R7: framing error
        send(8'h42, 0, 0, 0, 1);
        rd(4'h8, v); chk_eq("R7 framing error", v, 8'hD4);
        wr(4'h8, 8'hA4);
        rd(4'h8, v); chk_eq("R7 framing clear", v, 8'h84);

        // R7: parity error
        wr(4'h0, 8'h20);
        send(8'h81, 1, 0, 1, 0);
        rd(4'h8, v); chk_eq("R7 parity error", v, 8'hCC);
        wr(4'h8, 8'hA4);
        rd(4'h8, v); chk_eq("R7 parity clear", v, 8'h84);
        wr(4'h0, 8'h00);

        // R10: explicit interrupt checks
        wr(4'h4, 8'hF0);
        @(negedge clk);
        chk_eq("R10 tx irq", irq_tx, 1);
        chk_eq("R10 rx irq idle", irq_rx, 0);
        send(8'h5E, 0, 0, 0, 0);
        chk_eq("R10 rx irq", irq_rx, 1);
        chk_eq("R10 err irq quiet", irq_err, 0);
        send(8'h99, 0, 0, 0, 1);
        chk_eq("R10 err irq on overrun", irq_err, 1);
        wr(4'h4, 8'h30);
        @(negedge clk);
        chk_eq("R10 irqs masked", {irq_tx, irq_rx, irq_err}, 0);
        rd(4'h8, v); chk_eq("R6 overrun no framing", v, 8'hE4);
        wr(4'h8, 8'h84);
        rd(4'h8, v); chk_eq("R8 mixed clear", v, 8'h84);

        // R5: receiver disabled ignores the line
        wr(4'h4, 8'h20);
        send(8'h77, 0, 0, 0, 0);
        rd(4'h8, v); chk_eq("R5 disabled no flag", v, 8'h84);
        rd(4'hA, v); chk_eq("R5 disabled data kept", v, 8'h5E);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule